// File: doc/BRIEF.md
# Global Trigger Decision Unit

This block forms the final level-one trigger decision from time-stamped subsystem reports. Five sources feed it: two forward-calorimeter partial energies, two barrel-calorimeter partial energies and one forward track count. Every report carries the time stamp of the beam bucket it describes. Reports for one stamp may arrive in different clock cycles. The block holds one slot per source and releases an event only when all five slots carry the same stamp. It then adds each calorimeter pair.

For each event it computes an offset-protected energy ratio, (forward+1)/(barrel+1). A pipelined restoring divider produces this ratio, one quotient bit per stage. Four independent trigger conditions then each form a weighted score from the track count, the forward energy and the ratio. Each condition compares its score against its own threshold.

A passing condition does not fire when the arithmetic finishes. It fires a programmed number of cycles after the event's own time stamp. Downstream electronics therefore see a constant latency and can use a fixed look-back. Each condition has an enable and a delay. A delay too short for the compute pipeline is reported as a configuration error. The clock is the 250 MHz pipeline clock, and one time-stamp unit equals one clock cycle of 4 ns.

Top module: `gtrig_core`

## Requirements
- R1: While reset is held, and after its release until an event is scheduled, `trig_o` and `cfg_err` stay low.
- R2: Sources 0 and 1 (forward) are added to form EF, and sources 2 and 3 (barrel) are added to form EB. Both sums enter the score.
- R3: An event is formed once all five slots hold reports with equal stamps, however the reports were spread over cycles. Source index 4 is the track count T.
- R4: When all five slots are filled but their stamps differ, every slot whose stamp is not the largest (unsigned) is discarded. The newest report waits for its partners.
- R5: The score of condition k is Wt*T + We*EF + Wr*floor((EF+1)/(EB+1)), computed on unsigned integers.
- R6: A condition passes when its score is greater than or equal to its threshold. Equality passes, and a threshold one above the score does not.
- R7: A passing condition raises `trig_o[k]` for exactly one cycle, in the cycle where `now_ts` equals the event stamp plus `cfg_dly[k]`. `now_ts` must advance by one each clock.
- R8: During the pulse, `trig_ts[k]` equals the stamp of the event that caused it.
- R9: The four conditions use their own weights, thresholds and delays on the same event, and they fire independently.
- R10: A condition whose enable is low never raises its output, and its `cfg_err` stays low.
- R11: An enabled condition with a delay below 17 cycles (P_W+5 at the defaults) raises `cfg_err` and never fires. A delay of exactly 17 fires on time when all reports arrive in their own stamp's cycle.
- R12: An event is dropped without a pulse if its target cycle is not between 1 and 256 cycles after its decision cycle. This covers stale stamps and stamps too far ahead.
- R13: Events released in consecutive cycles each produce their own pulse, in consecutive cycles.
- R14: A report that arrives in the same cycle that a complete set is released is kept and counts toward the next event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pipeline clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| now_ts | input | TS_W | Current time stamp, incremented every cycle |
| rpt_vld | input | 5 | Report strobe per source (0,1 forward; 2,3 barrel; 4 tracks) |
| rpt_ts | input | 5 x TS_W | Report time stamp per source |
| rpt_val | input | 5 x P_W | Report value per source |
| cfg_en | input | TRIG_N | Enable per condition |
| cfg_w_trk | input | TRIG_N x W_W | Track-count weight per condition |
| cfg_w_en | input | TRIG_N x W_W | Forward-energy weight per condition |
| cfg_w_rat | input | TRIG_N x W_W | Ratio weight per condition |
| cfg_thr | input | TRIG_N x (P_W+W_W+3) | Score threshold per condition |
| cfg_dly | input | TRIG_N x DLY_W | Output delay from event stamp, in cycles |
| trig_o | output | TRIG_N | One-cycle trigger pulse per condition |
| trig_ts | output | TRIG_N x TS_W | Stamp of the event behind the pulse |
| cfg_err | output | TRIG_N | Enabled with a delay shorter than the compute latency |

## Verification
Two functions can land in the same clock: the release of a complete slot set, and the capture of a fresh report for the following stamp. The bench provokes this by presenting a new stamp's first report in the very cycle the previous set completes. It does the same in the stale-drop case, where the refill arrives in the cycle the old slots are cleared. It then checks that both events produce pulses with the right stamps and cycles. In a second collision, two events leave back to back, and the bench checks that their pulses stay separate in adjacent cycles with the correct tags.

// File: rtl/gtrig_pkg.sv
package gtrig_pkg;

    localparam int unsigned SRC_N   = 5;
    localparam int unsigned SRC_FA  = 0;
    localparam int unsigned SRC_FB  = 1;
    localparam int unsigned SRC_BA  = 2;
    localparam int unsigned SRC_BB  = 3;
    localparam int unsigned SRC_TRK = 4;

    typedef enum logic [1:0] {
        AL_IDLE   = 2'd0,
        AL_GATHER = 2'd1,
        AL_ISSUE  = 2'd2
    } aln_state_t;

    typedef enum logic [1:0] {
        CH_OFF  = 2'd0,
        CH_BAD  = 2'd1,
        CH_LIVE = 2'd2
    } ch_state_t;

endpackage

// File: rtl/gtrig_align.sv
module gtrig_align
    import gtrig_pkg::*;
#(
    parameter int unsigned TS_W = 16,
    parameter int unsigned P_W  = 12,
    localparam int unsigned N_W = P_W + 1
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic [SRC_N-1:0]                 rpt_vld,
    input  logic [SRC_N-1:0][TS_W-1:0]       rpt_ts,
    input  logic [SRC_N-1:0][P_W-1:0]        rpt_val,
    output logic                             ev_vld,
    output logic [TS_W-1:0]                  ev_ts,
    output logic [P_W-1:0]                   ev_t,
    output logic [N_W-1:0]                   ev_ef,
    output logic [N_W-1:0]                   ev_eb
);

    logic [SRC_N-1:0]            slot_vld_q, slot_vld_d;
    logic [SRC_N-1:0][TS_W-1:0]  slot_ts_q,  slot_ts_d;
    logic [SRC_N-1:0][P_W-1:0]   slot_val_q, slot_val_d;
    logic                        all_in, same, complete, clash;
    logic [TS_W-1:0]             newest;
    aln_state_t                  st_q, st_d;

    // Slot inspection: full set, equal stamps, newest stamp
    always_comb begin
        all_in = &slot_vld_q;
        same   = 1'b1;
        newest = slot_ts_q[0];
        for (int s = 1; s < SRC_N; s++) begin
            if (slot_ts_q[s] != slot_ts_q[0]) same = 1'b0;
            if (slot_ts_q[s] > newest)       newest = slot_ts_q[s];
        end
        complete = all_in && same;
        clash    = all_in && !same;
    end

    // Slot update: release or stale drop first, then incoming reports win
    always_comb begin
        for (int s = 0; s < SRC_N; s++) begin
            slot_vld_d[s] = slot_vld_q[s] && !complete &&
                            !(clash && (slot_ts_q[s] != newest));
            slot_ts_d[s]  = slot_ts_q[s];
            slot_val_d[s] = slot_val_q[s];
            if (rpt_vld[s]) begin
                slot_vld_d[s] = 1'b1;
                slot_ts_d[s]  = rpt_ts[s];
                slot_val_d[s] = rpt_val[s];
            end
        end
    end

    // Next-state logic
    always_comb begin
        unique case (st_q)
            AL_IDLE:   st_d = (|slot_vld_d) ? AL_GATHER : AL_IDLE;
            AL_GATHER: st_d = complete ? AL_ISSUE :
                              ((|slot_vld_d) ? AL_GATHER : AL_IDLE);
            AL_ISSUE:  st_d = complete ? AL_ISSUE :
                              ((|slot_vld_d) ? AL_GATHER : AL_IDLE);
            default:   st_d = AL_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q       <= AL_IDLE;
            slot_vld_q <= '0;
        end else begin
            st_q       <= st_d;
            slot_vld_q <= slot_vld_d;
        end
    end

    always_ff @(posedge clk) begin
        slot_ts_q  <= slot_ts_d;
        slot_val_q <= slot_val_d;
        if (complete) begin
            ev_ts <= slot_ts_q[0];
            ev_t  <= slot_val_q[SRC_TRK];
            ev_ef <= N_W'(slot_val_q[SRC_FA]) + N_W'(slot_val_q[SRC_FB]);
            ev_eb <= N_W'(slot_val_q[SRC_BA]) + N_W'(slot_val_q[SRC_BB]);
        end
    end

    // Output process
    always_comb begin
        ev_vld = (st_q == AL_ISSUE);
    end

endmodule

// File: rtl/gtrig_div.sv
module gtrig_div #(
    parameter int unsigned N_W  = 13,
    parameter int unsigned SB_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_vld,
    input  logic [N_W-1:0]   in_num,
    input  logic [N_W-1:0]   in_den,
    input  logic [SB_W-1:0]  in_sb,
    output logic             out_vld,
    output logic [N_W-1:0]   out_q,
    output logic [SB_W-1:0]  out_sb
);

    logic [N_W-1:0]            r_vld, n_vld;
    logic [N_W-1:0][N_W-1:0]   r_rem, n_rem;
    logic [N_W-1:0][N_W-1:0]   r_num, n_num;
    logic [N_W-1:0][N_W-1:0]   r_den, n_den;
    logic [N_W-1:0][N_W-1:0]   r_q,   n_q;
    logic [N_W-1:0][SB_W-1:0]  r_sb,  n_sb;

    // One restoring step per stage, numerator consumed from its top bit
    always_comb begin
        for (int i = 0; i < N_W; i++) begin
            logic [N_W-1:0] c_rem, c_num, c_den, c_q;
            logic [N_W:0]   shf;
            logic           take;
            if (i == 0) begin
                n_vld[i] = in_vld;
                c_rem    = '0;
                c_num    = in_num;
                c_den    = in_den;
                c_q      = '0;
                n_sb[i]  = in_sb;
            end else begin
                n_vld[i] = r_vld[i-1];
                c_rem    = r_rem[i-1];
                c_num    = r_num[i-1];
                c_den    = r_den[i-1];
                c_q      = r_q[i-1];
                n_sb[i]  = r_sb[i-1];
            end
            shf      = {c_rem, c_num[N_W-1-i]};
            take     = (shf >= {1'b0, c_den});
            n_rem[i] = take ? N_W'(shf - {1'b0, c_den}) : shf[N_W-1:0];
            n_q[i]   = {c_q[N_W-2:0], take};
            n_num[i] = c_num;
            n_den[i] = c_den;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_vld <= '0;
        else        r_vld <= n_vld;
    end

    always_ff @(posedge clk) begin
        r_rem <= n_rem;
        r_num <= n_num;
        r_den <= n_den;
        r_q   <= n_q;
        r_sb  <= n_sb;
    end

    assign out_vld = r_vld[N_W-1];
    assign out_q   = r_q[N_W-1];
    assign out_sb  = r_sb[N_W-1];

endmodule

// File: rtl/gtrig_chan.sv
module gtrig_chan
    import gtrig_pkg::*;
#(
    parameter int unsigned TS_W  = 16,
    parameter int unsigned P_W   = 12,
    parameter int unsigned W_W   = 8,
    parameter int unsigned DLY_W = 8,
    localparam int unsigned N_W   = P_W + 1,
    localparam int unsigned SC_W  = P_W + W_W + 3,
    localparam int unsigned LAT   = N_W + 4,
    localparam int unsigned DEPTH = 1 << DLY_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [TS_W-1:0]   now_ts,
    input  logic              in_vld,
    input  logic [TS_W-1:0]   in_ts,
    input  logic [P_W-1:0]    in_t,
    input  logic [N_W-1:0]    in_ef,
    input  logic [N_W-1:0]    in_q,
    input  logic              en,
    input  logic [W_W-1:0]    w_trk,
    input  logic [W_W-1:0]    w_en,
    input  logic [W_W-1:0]    w_rat,
    input  logic [SC_W-1:0]   thr,
    input  logic [DLY_W-1:0]  dly,
    output logic              trig,
    output logic [TS_W-1:0]   tag,
    output logic              err
);

    ch_state_t         st_q, st_d;
    logic              short_dly;
    logic [SC_W-1:0]   score;
    logic              hit_q;
    logic [TS_W-1:0]   hit_ts;
    logic [TS_W-1:0]   rem;
    logic              in_win;
    logic [DLY_W-1:0]  slot_idx;
    logic [DEPTH-1:0]  line_q, line_d;

    assign short_dly = (32'(dly) < LAT);

    // Next-state logic
    always_comb begin
        unique case (st_q)
            CH_OFF:  st_d = !en ? CH_OFF : (short_dly ? CH_BAD : CH_LIVE);
            CH_BAD:  st_d = !en ? CH_OFF : (short_dly ? CH_BAD : CH_LIVE);
            CH_LIVE: st_d = !en ? CH_OFF : (short_dly ? CH_BAD : CH_LIVE);
            default: st_d = CH_OFF;
        endcase
    end

    // Weighted score
    always_comb begin
        score = SC_W'(in_t)  * SC_W'(w_trk)
              + SC_W'(in_ef) * SC_W'(w_en)
              + SC_W'(in_q)  * SC_W'(w_rat);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) hit_q <= 1'b0;
        else        hit_q <= in_vld && (score >= thr);
    end

    always_ff @(posedge clk) begin
        hit_ts <= in_ts;
    end

    // Scheduling into the delay line
    always_comb begin
        rem      = hit_ts + TS_W'(dly) - now_ts;
        in_win   = !rem[TS_W-1] && (rem != '0) && (rem <= TS_W'(DEPTH));
        slot_idx = DLY_W'(rem - 1'b1);
        line_d   = line_q >> 1;
        if (hit_q && in_win && (st_q == CH_LIVE)) line_d[slot_idx] = 1'b1;
        if (st_d != CH_LIVE) line_d = '0;
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q   <= CH_OFF;
            line_q <= '0;
        end else begin
            st_q   <= st_d;
            line_q <= line_d;
        end
    end

    // Output process
    always_comb begin
        trig = line_q[0] && en && (st_q == CH_LIVE);
        err  = (st_q == CH_BAD);
        tag  = now_ts - TS_W'(dly);
    end

endmodule

// File: rtl/gtrig_core.sv
module gtrig_core
    import gtrig_pkg::*;
#(
    parameter int unsigned TS_W   = 16,
    parameter int unsigned P_W    = 12,
    parameter int unsigned W_W    = 8,
    parameter int unsigned DLY_W  = 8,
    parameter int unsigned TRIG_N = 4,
    localparam int unsigned N_W   = P_W + 1,
    localparam int unsigned SC_W  = P_W + W_W + 3,
    localparam int unsigned SB_W  = TS_W + P_W + N_W
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic [TS_W-1:0]                  now_ts,
    input  logic [SRC_N-1:0]                 rpt_vld,
    input  logic [SRC_N-1:0][TS_W-1:0]       rpt_ts,
    input  logic [SRC_N-1:0][P_W-1:0]        rpt_val,
    input  logic [TRIG_N-1:0]                cfg_en,
    input  logic [TRIG_N-1:0][W_W-1:0]       cfg_w_trk,
    input  logic [TRIG_N-1:0][W_W-1:0]       cfg_w_en,
    input  logic [TRIG_N-1:0][W_W-1:0]       cfg_w_rat,
    input  logic [TRIG_N-1:0][SC_W-1:0]      cfg_thr,
    input  logic [TRIG_N-1:0][DLY_W-1:0]     cfg_dly,
    output logic [TRIG_N-1:0]                trig_o,
    output logic [TRIG_N-1:0][TS_W-1:0]      trig_ts,
    output logic [TRIG_N-1:0]                cfg_err
);

    logic             ev_vld;
    logic [TS_W-1:0]  ev_ts;
    logic [P_W-1:0]   ev_t;
    logic [N_W-1:0]   ev_ef, ev_eb;
    logic             dv_vld;
    logic [N_W-1:0]   dv_q;
    logic [SB_W-1:0]  dv_sb;
    logic [TS_W-1:0]  dv_ts;
    logic [P_W-1:0]   dv_t;
    logic [N_W-1:0]   dv_ef;

    gtrig_align #(.TS_W(TS_W), .P_W(P_W)) u_align (
        .clk     (clk),
        .rst_n   (rst_n),
        .rpt_vld (rpt_vld),
        .rpt_ts  (rpt_ts),
        .rpt_val (rpt_val),
        .ev_vld  (ev_vld),
        .ev_ts   (ev_ts),
        .ev_t    (ev_t),
        .ev_ef   (ev_ef),
        .ev_eb   (ev_eb)
    );

    gtrig_div #(.N_W(N_W), .SB_W(SB_W)) u_div (
        .clk     (clk),
        .rst_n   (rst_n),
        .in_vld  (ev_vld),
        .in_num  (ev_ef + 1'b1),
        .in_den  (ev_eb + 1'b1),
        .in_sb   ({ev_ts, ev_t, ev_ef}),
        .out_vld (dv_vld),
        .out_q   (dv_q),
        .out_sb  (dv_sb)
    );

    assign {dv_ts, dv_t, dv_ef} = dv_sb;

    for (genvar gj = 0; gj < TRIG_N; gj++) begin : g_chan
        gtrig_chan #(.TS_W(TS_W), .P_W(P_W), .W_W(W_W), .DLY_W(DLY_W)) u_chan (
            .clk    (clk),
            .rst_n  (rst_n),
            .now_ts (now_ts),
            .in_vld (dv_vld),
            .in_ts  (dv_ts),
            .in_t   (dv_t),
            .in_ef  (dv_ef),
            .in_q   (dv_q),
            .en     (cfg_en[gj]),
            .w_trk  (cfg_w_trk[gj]),
            .w_en   (cfg_w_en[gj]),
            .w_rat  (cfg_w_rat[gj]),
            .thr    (cfg_thr[gj]),
            .dly    (cfg_dly[gj]),
            .trig   (trig_o[gj]),
            .tag    (trig_ts[gj]),
            .err    (cfg_err[gj])
        );
    end

endmodule

// File: rtl/gtrig_chk.sv
module gtrig_chk #(
    parameter int unsigned TRIG_N = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic [4:0]        rpt_vld,
    input logic              ev_vld,
    input logic [TRIG_N-1:0] cfg_en,
    input logic [TRIG_N-1:0] cfg_err,
    input logic [TRIG_N-1:0] trig_o
);

    always @(posedge clk) begin
        if (!rst_n) begin
            AST_RESET_QUIET: assert (trig_o == '0 && cfg_err == '0); // R1
        end
    end

    AST_ISSUE_FROM_REPORT: assert property (@(posedge clk) disable iff (!rst_n)
        ev_vld |-> $past(|rpt_vld, 2)); // R3

    for (genvar gj = 0; gj < TRIG_N; gj++) begin : g_chk
        AST_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
            !cfg_en[gj] |-> !trig_o[gj]); // R10
        AST_PULSE_WAS_ON: assert property (@(posedge clk) disable iff (!rst_n)
            trig_o[gj] |-> $past(cfg_en[gj])); // R10
        AST_BAD_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
            cfg_err[gj] |-> !trig_o[gj]); // R11
        AST_ERR_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
            cfg_err[gj] |-> $past(cfg_en[gj])); // R11
    end

endmodule

bind gtrig_core gtrig_chk #(.TRIG_N(TRIG_N)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .rpt_vld (rpt_vld),
    .ev_vld  (ev_vld),
    .cfg_en  (cfg_en),
    .cfg_err (cfg_err),
    .trig_o  (trig_o)
);

// File: tb/gtrig_core_tb.sv
module gtrig_core_tb;

    localparam int CLK_P  = 4;
    localparam int TS_W   = 16;
    localparam int P_W    = 12;
    localparam int W_W    = 8;
    localparam int DLY_W  = 8;
    localparam int TRIG_N = 4;
    localparam int SC_W   = P_W + W_W + 3;

    typedef struct packed {
        logic [11:0] fa, fb, ba, bb, t;
        logic [7:0]  wt, we, wr;
        logic [22:0] thr;
    } vec_t;

    localparam vec_t VT [7] = '{
        '{12'd10,   12'd20,   12'd5, 12'd5, 12'd3,    8'd2,   8'd1,   8'd4,   23'd44},
        '{12'd10,   12'd20,   12'd5, 12'd5, 12'd3,    8'd2,   8'd1,   8'd4,   23'd45},
        '{12'd0,    12'd0,    12'd0, 12'd0, 12'd0,    8'd9,   8'd9,   8'd7,   23'd7},
        '{12'd4095, 12'd4095, 12'd0, 12'd0, 12'd4095, 8'd255, 8'd255, 8'd255, 23'd5221380},
        '{12'd99,   12'd0,    12'd4, 12'd5, 12'd0,    8'd0,   8'd0,   8'd1,   23'd10},
        '{12'd99,   12'd0,    12'd4, 12'd5, 12'd0,    8'd0,   8'd0,   8'd1,   23'd11},
        '{12'd0,    12'd0,    12'd0, 12'd0, 12'd100,  8'd3,   8'd0,   8'd0,   23'd301}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [TS_W-1:0] now_ts = '0;
    logic [4:0] rpt_vld = '0;
    logic [4:0][TS_W-1:0] rpt_ts = '0;
    logic [4:0][P_W-1:0] rpt_val = '0;
    logic [TRIG_N-1:0] cfg_en = '0;
    logic [TRIG_N-1:0][W_W-1:0] cfg_w_trk = '0, cfg_w_en = '0, cfg_w_rat = '0;
    logic [TRIG_N-1:0][SC_W-1:0] cfg_thr = '0;
    logic [TRIG_N-1:0][DLY_W-1:0] cfg_dly = '0;
    logic [TRIG_N-1:0] trig_o;
    logic [TRIG_N-1:0][TS_W-1:0] trig_ts;
    logic [TRIG_N-1:0] cfg_err;

    int n_chk = 0, n_err = 0;
    int cnt [TRIG_N];
    int last_now [TRIG_N];
    int last_tag [TRIG_N];
    int log_now [16];
    int log_tag [16];
    bit done = 0;

    gtrig_core #(.TS_W(TS_W), .P_W(P_W), .W_W(W_W), .DLY_W(DLY_W), .TRIG_N(TRIG_N)) u_dut (
        .clk(clk), .rst_n(rst_n), .now_ts(now_ts),
        .rpt_vld(rpt_vld), .rpt_ts(rpt_ts), .rpt_val(rpt_val),
        .cfg_en(cfg_en), .cfg_w_trk(cfg_w_trk), .cfg_w_en(cfg_w_en), .cfg_w_rat(cfg_w_rat),
        .cfg_thr(cfg_thr), .cfg_dly(cfg_dly),
        .trig_o(trig_o), .trig_ts(trig_ts), .cfg_err(cfg_err)
    );

    always #(CLK_P/2) clk = ~clk;
    always @(posedge clk) now_ts <= now_ts + 1'b1;

    initial begin
        for (int j = 0; j < TRIG_N; j++) cnt[j] = 0;
    end

    // Pulse monitor, sampled away from the active edge
    always @(negedge clk) begin
        if (rst_n) begin
            for (int j = 0; j < TRIG_N; j++) begin
                if (trig_o[j]) begin
                    if (j == 0) begin
                        log_now[cnt[0] % 16] = int'(now_ts);
                        log_tag[cnt[0] % 16] = int'(trig_ts[0]);
                    end
                    cnt[j]++;
                    last_now[j] = int'(now_ts);
                    last_tag[j] = int'(trig_ts[j]);
                end
            end
        end
    end

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Drive the masked sources for one cycle with a shared stamp
    task automatic put(input logic [4:0] mask, input int ts, input int v0, input int v1,
                       input int v2, input int v3, input int v4);
        int vv [5];
        vv = '{v0, v1, v2, v3, v4};
        for (int s = 0; s < 5; s++) begin
            rpt_vld[s] = mask[s];
            rpt_ts[s]  = TS_W'(ts);
            rpt_val[s] = P_W'(vv[s]);
        end
        @(negedge clk);
        rpt_vld = '0;
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic cfg(input int j, input bit en, input int wt, input int we, input int wr,
                       input longint thr, input int dly);
        cfg_en[j]    = en;
        cfg_w_trk[j] = W_W'(wt);
        cfg_w_en[j]  = W_W'(we);
        cfg_w_rat[j] = W_W'(wr);
        cfg_thr[j]   = SC_W'(thr);
        cfg_dly[j]   = DLY_W'(dly);
    endtask

    function automatic bit exp_hit(input vec_t v);
        longint ef, eb, sc;
        ef = longint'(v.fa) + longint'(v.fb);
        eb = longint'(v.ba) + longint'(v.bb);
        sc = longint'(v.wt) * longint'(v.t) + longint'(v.we) * ef
           + longint'(v.wr) * ((ef + 1) / (eb + 1));
        return sc >= longint'(v.thr);
    endfunction

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

    initial begin : main
        int ts, c0, c1, c2, c3;
        // R1: quiet under reset even with an enabled short delay
        cfg(0, 1'b1, 0, 0, 0, 0, 5);
        wait_cyc(3);
        chk(trig_o == '0, "R1 trig in reset", trig_o, 0);
        chk(cfg_err == '0, "R1 err in reset", cfg_err, 0);
        cfg(0, 1'b0, 0, 0, 0, 0, 40);
        rst_n = 1'b1;
        wait_cyc(4);
        chk(trig_o == '0 && cfg_err == '0, "R1 after release", trig_o, 0);

        // Table walk on condition 0: R2 R5 R6 R7 R8
        for (int k = 0; k < 7; k++) begin
            cfg(0, 1'b1, VT[k].wt, VT[k].we, VT[k].wr, VT[k].thr, 40);
            wait_cyc(2);
            c0 = cnt[0];
            ts = int'(now_ts);
            put(5'b11111, ts, VT[k].fa, VT[k].fb, VT[k].ba, VT[k].bb, VT[k].t);
            wait_cyc(45);
            chk(cnt[0] - c0 == (exp_hit(VT[k]) ? 1 : 0), "R2 R5 R6 vector hit",
                cnt[0] - c0, exp_hit(VT[k]) ? 1 : 0);
            if (exp_hit(VT[k])) begin
                chk(last_now[0] == ((ts + 40) % 65536), "R7 pulse cycle", last_now[0], (ts + 40) % 65536);
                chk(last_tag[0] == ts, "R8 pulse tag", last_tag[0], ts);
            end
        end

        // Always-pass setup for timing tests
        cfg(0, 1'b1, 0, 0, 0, 0, 40);
        wait_cyc(2);

        // R3: staggered arrival of one stamp
        c0 = cnt[0];
        ts = int'(now_ts);
        put(5'b00011, ts, 1, 1, 0, 0, 0);
        put(5'b00100, ts, 0, 0, 1, 0, 0);
        wait_cyc(1);
        put(5'b11000, ts, 0, 0, 0, 1, 2);
        wait_cyc(45);
        chk(cnt[0] - c0 == 1, "R3 staggered count", cnt[0] - c0, 1);
        chk(last_now[0] == ts + 40, "R3 staggered cycle", last_now[0], ts + 40);

        // R4 with R14-style collision: stale set dropped, refill in the clearing cycle
        c0 = cnt[0];
        ts = int'(now_ts);
        put(5'b01111, ts, 1, 1, 1, 1, 0);
        put(5'b10000, ts + 1, 0, 0, 0, 0, 1);
        put(5'b01111, ts + 1, 1, 1, 1, 1, 0);
        wait_cyc(45);
        chk(cnt[0] - c0 == 1, "R4 stale dropped count", cnt[0] - c0, 1);
        chk(last_tag[0] == ts + 1, "R4 newest kept tag", last_tag[0], ts + 1);

        // R14: a report arriving in the release cycle feeds the next event
        c0 = cnt[0];
        ts = int'(now_ts);
        put(5'b01111, ts, 1, 1, 1, 1, 0);
        put(5'b10000, ts, 0, 0, 0, 0, 1);
        put(5'b00001, ts + 2, 1, 0, 0, 0, 0);
        put(5'b11110, ts + 2, 0, 1, 1, 1, 1);
        wait_cyc(45);
        chk(cnt[0] - c0 == 2, "R14 both events count", cnt[0] - c0, 2);
        chk(log_tag[c0 % 16] == ts, "R14 first tag", log_tag[c0 % 16], ts);
        chk(log_tag[(c0 + 1) % 16] == ts + 2, "R14 second tag", log_tag[(c0 + 1) % 16], ts + 2);

        // R13: consecutive events
        c0 = cnt[0];
        ts = int'(now_ts);
        put(5'b11111, ts, 1, 1, 1, 1, 1);
        put(5'b11111, ts + 1, 2, 2, 2, 2, 2);
        wait_cyc(45);
        chk(cnt[0] - c0 == 2, "R13 pulse count", cnt[0] - c0, 2);
        chk(log_now[(c0 + 1) % 16] - log_now[c0 % 16] == 1, "R13 adjacent cycles",
            log_now[(c0 + 1) % 16] - log_now[c0 % 16], 1);
        chk(log_tag[(c0 + 1) % 16] == ts + 1, "R13 second tag", log_tag[(c0 + 1) % 16], ts + 1);

        // R9: four conditions on one event
        cfg(0, 1'b1, 0, 0, 0, 0, 20);
        cfg(1, 1'b1, 0, 0, 0, 0, 30);
        cfg(2, 1'b1, 0, 0, 0, 0, 45);
        cfg(3, 1'b1, 1, 1, 1, 8000000, 25);
        wait_cyc(2);
        c0 = cnt[0]; c1 = cnt[1]; c2 = cnt[2]; c3 = cnt[3];
        ts = int'(now_ts);
        put(5'b11111, ts, 3, 3, 3, 3, 3);
        wait_cyc(50);
        chk(last_now[0] == ts + 20 && cnt[0] - c0 == 1, "R9 cond0", last_now[0], ts + 20);
        chk(last_now[1] == ts + 30 && cnt[1] - c1 == 1, "R9 cond1", last_now[1], ts + 30);
        chk(last_now[2] == ts + 45 && cnt[2] - c2 == 1, "R9 cond2", last_now[2], ts + 45);
        chk(cnt[3] - c3 == 0, "R9 cond3 below threshold", cnt[3] - c3, 0);
        chk(last_tag[2] == ts, "R9 R8 cond2 tag", last_tag[2], ts);

        // R10: disabled condition stays silent and reports no error
        cfg(1, 1'b0, 0, 0, 0, 0, 5);
        wait_cyc(2);
        chk(cfg_err[1] == 1'b0, "R10 no error when off", cfg_err[1], 0);
        c0 = cnt[0]; c1 = cnt[1];
        ts = int'(now_ts);
        put(5'b11111, ts, 1, 1, 1, 1, 1);
        wait_cyc(50);
        chk(cnt[1] - c1 == 0, "R10 disabled quiet", cnt[1] - c1, 0);
        chk(cnt[0] - c0 == 1, "R10 neighbour fires", cnt[0] - c0, 1);

        // R11: delay boundary
        cfg(2, 1'b1, 0, 0, 0, 0, 16);
        cfg(0, 1'b1, 0, 0, 0, 0, 17);
        wait_cyc(2);
        chk(cfg_err[2] == 1'b1, "R11 short delay flagged", cfg_err[2], 1);
        chk(cfg_err[0] == 1'b0, "R11 minimum delay accepted", cfg_err[0], 0);
        c0 = cnt[0]; c2 = cnt[2];
        ts = int'(now_ts);
        put(5'b11111, ts, 1, 1, 1, 1, 1);
        wait_cyc(30);
        chk(cnt[2] - c2 == 0, "R11 flagged quiet", cnt[2] - c2, 0);
        chk(cnt[0] - c0 == 1 && last_now[0] == ts + 17, "R11 minimum fires on time", last_now[0], ts + 17);
        cfg(2, 1'b0, 0, 0, 0, 0, 45);
        cfg(3, 1'b0, 0, 0, 0, 0, 25);

        // R12: stale and far-future stamps dropped
        cfg(0, 1'b1, 0, 0, 0, 0, 40);
        wait_cyc(2);
        c0 = cnt[0];
        ts = int'(now_ts);
        put(5'b11111, ts - 30, 1, 1, 1, 1, 1);
        wait_cyc(60);
        chk(cnt[0] - c0 == 0, "R12 stale dropped", cnt[0] - c0, 0);
        ts = int'(now_ts);
        put(5'b11111, ts + 300, 1, 1, 1, 1, 1);
        wait_cyc(360);
        chk(cnt[0] - c0 == 0, "R12 far future dropped", cnt[0] - c0, 0);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

endmodule